// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block is the timing master for interlaced television rasters of 525 or 625 lines per frame. It counts clock cycles inside each half-line and counts half-lines across the frame. From those counts it decodes the horizontal sync, the vertical sync and the field indicator, and it makes the half-line and line numbers available to the downstream video logic.

Each frame has two interlaced fields. The odd field opens with horizontal and vertical sync on the same clock. The even field opens with vertical sync in the middle of a line. Vertical sync lasts six half-lines in 525-line operation and five half-lines in 625-line operation. The field indicator moves a fixed number of clocks before each vertical sync leading edge. Each of the three pins has its own polarity control, and a standard change requested on the select input waits until the frame in progress has finished.

Top module: `vt_sync_gen`

## Requirements
- R1: On the first clock after reset is released, the half-line count is 0, and horizontal sync and vertical sync are both active on that same cycle.
- R2: A half-line is half a line period (858 clocks for 525-line, 864 for 625-line). The half-line count advances by one at the end of each half-line. It wraps to 0 after 1049 (525-line) or 1249 (625-line). The line count always equals the half-line count divided by two, rounded down.
- R3: Horizontal sync is active for exactly 127 clocks at the start of every even-numbered half-line, which is the start of a line, and is inactive the rest of the time.
- R4: In the odd field, vertical sync is active from half-line 0 for 6 half-lines (525-line) or 5 half-lines (625-line).
- R5: In the even field, vertical sync starts at half-line 525 (525-line) or 625 (625-line). That is the middle of a line, where horizontal sync is inactive. It lasts the same number of half-lines as in R4.
- R6: The field indicator is at its odd level during the odd field. It changes level exactly 32 clocks before each vertical sync leading edge.
- R7: Each pin has its own polarity bit. With polarity 0, horizontal and vertical sync are low while active and the field pin is low during the odd field. With polarity 1, that pin is inverted. A polarity change shows on the pin in the same cycle.
- R8: While reset is held, both sync pins are at their inactive level, the field pin is at its odd-field level, and both counts are 0.
- R9: The standard select (0 = 525-line, 1 = 625-line) is sampled during reset and again when the half-line count wraps to 0. A change at any other time does not affect the frame in progress.
- R10: A line is 1716 clocks with 525 lines per frame in 525-line operation, and 1728 clocks with 625 lines per frame in 625-line operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock (twice the sample rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| std_sel | input | 1 | Requested standard: 0 = 525-line, 1 = 625-line |
| pol_hsync | input | 1 | Horizontal sync polarity, 1 = active high |
| pol_vsync | input | 1 | Vertical sync polarity, 1 = active high |
| pol_field | input | 1 | Field pin polarity, 1 = high during odd field |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | Field indicator |
| half_cnt | output | HL_W (11) | Half-line number within the frame |
| line_cnt | output | HL_W-1 (10) | Line number within the frame |

## Verification
A wrong clock-in-half-line position shows up within one line, as a sync pulse of the wrong width or in the wrong place. A wrong half-line count shows up at the next vertical sync as an edge on the wrong half-line, or mid-line when it should be line-aligned. A field register that toggled in the wrong place shows up as a wrong lead to the next vertical sync edge, at most one field later. A standard latched at the wrong moment changes the line length inside a frame, and that is visible on the count outputs straight away.

// File: rtl/vt_sync_pkg.sv
// Shared definitions for the interlaced sync timing generator.
// Assumes: output vector positions below are used by every sub-block.
package vt_sync_pkg;
    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } vt_std_e;

    localparam int SIG_HS  = 0;
    localparam int SIG_VS  = 1;
    localparam int SIG_FLD = 2;
    localparam int SIG_NUM = 3;
endpackage

// File: rtl/vt_line_counter.sv
// Clock-in-half-line and half-line-in-frame counters with standard latch.
// Assumes: line periods are even; the standard is taken only at frame wrap
// (or during reset) so a frame never mixes two line lengths.
module vt_line_counter
    import vt_sync_pkg::*;
#(
    parameter int LINE_CLK_525 = 1716,
    parameter int LINE_CLK_625 = 1728,
    parameter int LINES_525    = 525,
    parameter int LINES_625    = 625,
    parameter int HP_W         = 10,
    parameter int HL_W         = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  vt_std_e         std_sel,
    output logic            run,
    output vt_std_e         std_cur,
    output logic [HP_W-1:0] hpos,
    output logic [HL_W-1:0] half_cnt,
    output logic [HP_W-1:0] half_len,
    output logic [HL_W-1:0] lines_num
);
    localparam logic [HP_W-1:0] HALF_525 = HP_W'(LINE_CLK_525 / 2);
    localparam logic [HP_W-1:0] HALF_625 = HP_W'(LINE_CLK_625 / 2);
    localparam logic [HL_W-1:0] NUM_525  = HL_W'(LINES_525);
    localparam logic [HL_W-1:0] NUM_625  = HL_W'(LINES_625);

    logic end_of_half;
    logic end_of_frame;

    // Geometry of the standard currently in force.
    always_comb begin
        half_len  = (std_cur == STD_625) ? HALF_625 : HALF_525;
        lines_num = (std_cur == STD_625) ? NUM_625  : NUM_525;
    end

    // Wrap points of the two counters.
    assign end_of_half  = (hpos == half_len - 1'b1);
    assign end_of_frame = (half_cnt == (lines_num << 1) - 1'b1);

    // Advance counters; hold at zero for one cycle after reset, latch standard at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            hpos     <= '0;
            half_cnt <= '0;
            std_cur  <= std_sel;
        end else if (!run) begin
            run <= 1'b1;
        end else if (end_of_half) begin
            hpos <= '0;
            if (end_of_frame) begin
                half_cnt <= '0;
                std_cur  <= std_sel;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end else begin
            hpos <= hpos + 1'b1;
        end
    end
endmodule

// File: rtl/vt_sync_decode.sv
// Decodes active-high horizontal sync, vertical sync and odd-field flag
// from the counters. Assumes an odd number of lines per frame, and a
// field lead shorter than one half-line.
module vt_sync_decode
    import vt_sync_pkg::*;
#(
    parameter int HS_WIDTH      = 127,
    parameter int VS_HALVES_525 = 6,
    parameter int VS_HALVES_625 = 5,
    parameter int FIELD_LEAD    = 32,
    parameter int HP_W          = 10,
    parameter int HL_W          = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  vt_std_e         std_cur,
    input  logic [HP_W-1:0] hpos,
    input  logic [HL_W-1:0] half_cnt,
    input  logic [HP_W-1:0] half_len,
    input  logic [HL_W-1:0] lines_num,
    output logic            hs_act,
    output logic            vs_act,
    output logic            fld_odd
);
    localparam logic [HP_W-1:0] HS_W_V = HP_W'(HS_WIDTH);
    localparam logic [HP_W-1:0] LEAD_V = HP_W'(FIELD_LEAD);
    localparam logic [HL_W-1:0] VH_525 = HL_W'(VS_HALVES_525);
    localparam logic [HL_W-1:0] VH_625 = HL_W'(VS_HALVES_625);

    logic [HL_W-1:0] vs_len;
    logic            in_odd_vs;
    logic            in_even_vs;
    logic            fld_toggle;
    logic            fld_even;

    // Vertical sync length for the current standard.
    assign vs_len = (std_cur == STD_625) ? VH_625 : VH_525;

    // Line-start horizontal pulse.
    assign hs_act = run && !half_cnt[0] && (hpos < HS_W_V);

    // Odd field sync from half-line 0, even field sync from mid-frame.
    assign in_odd_vs  = (half_cnt < vs_len);
    assign in_even_vs = (half_cnt >= lines_num) && (half_cnt < lines_num + vs_len);
    assign vs_act     = run && (in_odd_vs || in_even_vs);

    // Toggle point: the clock before the field lead window opens.
    assign fld_toggle = run && (hpos == half_len - LEAD_V - 1'b1) &&
                        ((half_cnt == lines_num - 1'b1) ||
                         (half_cnt == (lines_num << 1) - 1'b1));

    // Field flag register, odd after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_even <= 1'b0;
        end else if (fld_toggle) begin
            fld_even <= ~fld_even;
        end
    end

    assign fld_odd = ~fld_even;
endmodule

// File: rtl/vt_pol_out.sv
// Applies a per-signal polarity bit to active-high timing flags.
// Assumes: polarity 0 means the pin is low while its flag is set.
module vt_pol_out #(
    parameter int N = 3
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] pol,
    output logic [N-1:0] pin
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        // Drive pin to the polarity level while active, else its complement.
        assign pin[g] = act[g] ? pol[g] : ~pol[g];
    end
endmodule

// File: rtl/vt_sync_gen.sv
// Top of the interlaced sync timing generator (timing master only).
// Assumes: clk is the line-rate multiple given by the LINE_CLK parameters;
// lines per frame odd; FIELD_LEAD below half a line period.
module vt_sync_gen
    import vt_sync_pkg::*;
#(
    parameter int LINE_CLK_525  = 1716,
    parameter int LINE_CLK_625  = 1728,
    parameter int LINES_525     = 525,
    parameter int LINES_625     = 625,
    parameter int HS_WIDTH      = 127,
    parameter int VS_HALVES_525 = 6,
    parameter int VS_HALVES_625 = 5,
    parameter int FIELD_LEAD    = 32,
    localparam int LINES_MAX    = (LINES_525 > LINES_625) ? LINES_525 : LINES_625,
    localparam int CLK_MAX      = (LINE_CLK_525 > LINE_CLK_625) ? LINE_CLK_525 : LINE_CLK_625,
    localparam int HP_W         = $clog2(CLK_MAX / 2 + 1),
    localparam int HL_W         = $clog2(2 * LINES_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            std_sel,
    input  logic            pol_hsync,
    input  logic            pol_vsync,
    input  logic            pol_field,
    output logic            hsync,
    output logic            vsync,
    output logic            field,
    output logic [HL_W-1:0] half_cnt,
    output logic [HL_W-2:0] line_cnt
);
    logic               run;
    vt_std_e            std_cur;
    logic [HP_W-1:0]    hpos;
    logic [HP_W-1:0]    half_len;
    logic [HL_W-1:0]    lines_num;
    logic               hs_act;
    logic               vs_act;
    logic               fld_odd;
    logic [SIG_NUM-1:0] act_vec;
    logic [SIG_NUM-1:0] pol_vec;
    logic [SIG_NUM-1:0] pin_vec;

    vt_line_counter #(
        .LINE_CLK_525 (LINE_CLK_525),
        .LINE_CLK_625 (LINE_CLK_625),
        .LINES_525    (LINES_525),
        .LINES_625    (LINES_625),
        .HP_W         (HP_W),
        .HL_W         (HL_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_sel   (vt_std_e'(std_sel)),
        .run       (run),
        .std_cur   (std_cur),
        .hpos      (hpos),
        .half_cnt  (half_cnt),
        .half_len  (half_len),
        .lines_num (lines_num)
    );

    vt_sync_decode #(
        .HS_WIDTH      (HS_WIDTH),
        .VS_HALVES_525 (VS_HALVES_525),
        .VS_HALVES_625 (VS_HALVES_625),
        .FIELD_LEAD    (FIELD_LEAD),
        .HP_W          (HP_W),
        .HL_W          (HL_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .std_cur   (std_cur),
        .hpos      (hpos),
        .half_cnt  (half_cnt),
        .half_len  (half_len),
        .lines_num (lines_num),
        .hs_act    (hs_act),
        .vs_act    (vs_act),
        .fld_odd   (fld_odd)
    );

    // Gather flags and polarities in package order.
    always_comb begin
        act_vec          = '0;
        pol_vec          = '0;
        act_vec[SIG_HS]  = hs_act;
        act_vec[SIG_VS]  = vs_act;
        act_vec[SIG_FLD] = fld_odd;
        pol_vec[SIG_HS]  = pol_hsync;
        pol_vec[SIG_VS]  = pol_vsync;
        pol_vec[SIG_FLD] = pol_field;
    end

    vt_pol_out #(.N(SIG_NUM)) u_pol (
        .act (act_vec),
        .pol (pol_vec),
        .pin (pin_vec)
    );

    assign hsync    = pin_vec[SIG_HS];
    assign vsync    = pin_vec[SIG_VS];
    assign field    = pin_vec[SIG_FLD];
    assign line_cnt = half_cnt[HL_W-1:1];
endmodule

// File: rtl/vt_sync_gen_chk.sv
// Timing checker for vt_sync_gen, attached by bind. Observes pins,
// polarity inputs, counts and the latched standard.
module vt_sync_gen_chk #(
    parameter int FIELD_LEAD = 32,
    parameter int HL_W       = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pol_hsync,
    input logic            pol_vsync,
    input logic            pol_field,
    input logic            hsync,
    input logic            vsync,
    input logic            field,
    input logic [HL_W-1:0] half_cnt,
    input logic            std_cur
);
    localparam int SW = $clog2(FIELD_LEAD + 2);
    localparam logic [SW-1:0] LEAD_V = SW'(FIELD_LEAD);
    localparam logic [SW-1:0] SAT_V  = SW'(FIELD_LEAD + 1);

    logic          hs_a;
    logic          vs_a;
    logic          fld_even;
    logic          fld_prev;
    logic          fld_chg;
    logic          seen_chg;
    logic [SW-1:0] since_chg;

    // Polarity-independent views of the pins.
    assign hs_a     = (hsync == pol_hsync);
    assign vs_a     = (vsync == pol_vsync);
    assign fld_even = field ^ pol_field;
    assign fld_chg  = (fld_even != fld_prev);

    // Count clocks since the last field pin change, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_prev  <= 1'b0;
            seen_chg  <= 1'b0;
            since_chg <= '0;
        end else begin
            fld_prev <= fld_even;
            if (fld_chg) begin
                seen_chg  <= 1'b1;
                since_chg <= SW'(1);
            end else if (since_chg != SAT_V) begin
                since_chg <= since_chg + 1'b1;
            end
        end
    end

    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hs_a && !vs_a && !fld_even && half_cnt == '0));

    a_r2_half_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_cnt) |-> (half_cnt == $past(half_cnt) + 1'b1 || half_cnt == '0));

    a_r3_hs_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_a) |-> !half_cnt[0]);

    a_r4_odd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vs_a) && half_cnt == '0) |-> hs_a);

    a_r5_even_midline: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vs_a) && half_cnt != '0) |-> (!hs_a && half_cnt[0]));

    a_r6_field_lead: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vs_a) && seen_chg) |-> since_chg == LEAD_V);

    a_r9_std_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_cur) |-> half_cnt == '0);
endmodule

bind vt_sync_gen vt_sync_gen_chk #(
    .FIELD_LEAD (FIELD_LEAD),
    .HL_W       (HL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pol_hsync (pol_hsync),
    .pol_vsync (pol_vsync),
    .pol_field (pol_field),
    .hsync     (hsync),
    .vsync     (vsync),
    .field     (field),
    .half_cnt  (half_cnt),
    .std_cur   (std_cur)
);

// File: tb/sim_vt_sync_gen.sv
// Scoreboard bench: a reference model pushes per-cycle expectations,
// a monitor pops and compares them against the pins at the falling edge.
module sim_vt_sync_gen;
    localparam int LA   = 40;
    localparam int LB   = 48;
    localparam int NA   = 9;
    localparam int NB   = 7;
    localparam int HSW  = 6;
    localparam int VHA  = 6;
    localparam int VHB  = 5;
    localparam int LEAD = 4;
    localparam int HLW  = $clog2(2 * ((NA > NB) ? NA : NB) + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           std_sel = 1'b0;
    logic           pol_hs = 1'b0;
    logic           pol_vs = 1'b0;
    logic           pol_fld = 1'b0;
    logic           hsync;
    logic           vsync;
    logic           field;
    logic [HLW-1:0] half_cnt;
    logic [HLW-2:0] line_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit hs;
        bit vs;
        bit odd;
        bit run;
        bit first;
        int half;
    } exp_t;

    exp_t q[$];
    exp_t cur;

    int mp = 0;
    bit mstd = 1'b0;
    bit mrun = 1'b0;
    bit mfirst = 1'b0;
    int m_half, m_nl, m_vh, m_hl, m_hp;

    always #5 clk = ~clk;

    vt_sync_gen #(
        .LINE_CLK_525  (LA),
        .LINE_CLK_625  (LB),
        .LINES_525     (NA),
        .LINES_625     (NB),
        .HS_WIDTH      (HSW),
        .VS_HALVES_525 (VHA),
        .VS_HALVES_625 (VHB),
        .FIELD_LEAD    (LEAD)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_sel   (std_sel),
        .pol_hsync (pol_hs),
        .pol_vsync (pol_vs),
        .pol_field (pol_fld),
        .hsync     (hsync),
        .vsync     (vsync),
        .field     (field),
        .half_cnt  (half_cnt),
        .line_cnt  (line_cnt)
    );

    task automatic push_exp(input exp_t e);
        q.push_back(e);
    endtask

    // Reference model: advance the position and push the expected raw flags.
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            mrun = 1'b0; mp = 0; mstd = std_sel; mfirst = 1'b0;
        end else if (!mrun) begin
            mrun = 1'b1; mp = 0; mfirst = 1'b1;
        end else begin
            mp++;
            if (mp == (mstd ? NB * LB : NA * LA)) begin
                mp = 0; mstd = std_sel; mfirst = 1'b0;
            end
        end
        m_half = mstd ? LB / 2 : LA / 2;
        m_nl   = mstd ? NB : NA;
        m_vh   = mstd ? VHB : VHA;
        m_hl   = mp / m_half;
        m_hp   = mp % m_half;
        e.run   = mrun;
        e.first = mfirst && (mp == 0);
        e.half  = m_hl;
        e.hs    = mrun && (m_hl % 2 == 0) && (m_hp < HSW);
        e.vs    = mrun && ((m_hl < m_vh) || (m_hl >= m_nl && m_hl < m_nl + m_vh));
        e.odd   = !(mrun && mp >= m_nl * m_half - LEAD && mp < 2 * m_nl * m_half - LEAD);
        push_exp(e);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pop one expectation per cycle and compare at the falling edge.
    always @(negedge clk) begin
        if (!done && q.size() > 0) begin
            cur = q.pop_front();
            check(cur.run ? (cur.first ? "R1 R3 R7 hsync" : "R3 R7 hsync") : "R8 hsync",
                  int'(hsync), int'(cur.hs ? pol_hs : !pol_hs));
            check(cur.run ? (cur.first ? "R1 R4 R7 vsync" : "R4 R5 R7 vsync") : "R8 vsync",
                  int'(vsync), int'(cur.vs ? pol_vs : !pol_vs));
            check(cur.run ? "R6 R7 field" : "R8 field",
                  int'(field), int'(cur.odd ? pol_fld : !pol_fld));
            check(cur.run ? "R2 R9 R10 half_cnt" : "R8 half_cnt", int'(half_cnt), cur.half);
            check("R2 line_cnt", int'(line_cnt), cur.half / 2);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Stimulus: two standards, mid-frame standard requests, polarity flips, re-reset.
    initial begin
        step(5);
        rst_n = 1'b1;
        step(740);
        std_sel = 1'b1;
        step(1050);
        pol_hs = 1'b1; pol_vs = 1'b1; pol_fld = 1'b1;
        step(200);
        pol_vs = 1'b0; pol_fld = 1'b0;
        step(100);
        std_sel = 1'b0;
        step(800);
        rst_n = 1'b0; pol_hs = 1'b1; pol_vs = 1'b1; pol_fld = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(60);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule